// File: doc/BRIEF.md
# Control Transfer Resolution Unit

This unit settles where a 64-bit load/store processor with 32-bit instructions goes next. It is given one instruction word, the address that follows that instruction, and the operand values read for its two register fields. From these it decides whether control leaves the sequential path and where it lands. It also decides whether a return address must be written back, and to which register.

Direct branches carry a 21-bit word displacement that is scaled by four and added to the sequential address. Conditional branches test the first register operand for either its lowest bit or a signed relation to zero. Register-indirect jumps take their destination from the second operand, forced to word alignment. Any other opcode is flagged as illegal.

The decision logic is purely combinational. A thin registered stage presents every result one clock after a valid input strobe and holds it until the next strobe arrives.

Top module: `ctl_xfer_unit`

## Requirements
- R1: `res_vld` is high in the cycle after a cycle in which `req_vld` was sampled high, and low after a cycle in which it was sampled low.
- R2: After reset, all outputs are zero.
- R3: Opcode field bits 31:26 equal to 0x30 or 0x34 give `taken`=1. The target is the sequential address plus the value of bits 20:0, read as a signed number and multiplied by four. A field of 0x100000 therefore means -0x400000.
- R4: Opcodes 0x30, 0x34 and 0x1A write the sequential address to the register named by bits 25:21. They set `link_we`=1, `link_idx` to that field and `link_val` to the sequential address. When the field is 31, `link_we`=0. Whenever `link_we`=0, `link_idx` and `link_val` are 0.
- R5: Opcode 0x38 is taken when bit 0 of the first operand is 0. Opcode 0x3C is taken when that bit is 1.
- R6: Opcode 0x39 is taken when the first operand is zero. Opcode 0x3D is taken when it is nonzero.
- R7: Opcodes 0x3A, 0x3B, 0x3E and 0x3F are taken when the first operand, read as signed, is below zero, at most zero, at least zero and above zero, respectively.
- R8: Opcode 0x1A is always taken. Its target is the second operand (register field bits 20:16) with bits 1:0 cleared.
- R9: A conditional branch that is not taken gives `taken`=0, target equal to the sequential address, and no link write.
- R10: Every other opcode gives `illegal`=1, `taken`=0, `link_we`=0, and a target equal to the sequential address.
- R11: While `req_vld` is low, the result outputs other than `res_vld` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Input strobe, captures the instruction |
| insn | input | 32 | Instruction word |
| seq_pc | input | 64 | Address of the next sequential instruction |
| opa_val | input | 64 | Value of the register in bits 25:21 |
| opb_val | input | 64 | Value of the register in bits 20:16 |
| res_vld | output | 1 | Result valid, one cycle after the strobe |
| taken | output | 1 | Control leaves the sequential path |
| target | output | 64 | Next fetch address |
| link_we | output | 1 | Return-address write enable |
| link_idx | output | 5 | Return-address register index |
| link_val | output | 64 | Return-address value |
| illegal | output | 1 | Opcode is not a control transfer |

## Verification
Every conditional opcode is driven with operands at the edges of its relation: zero, minus one, plus one, and the most negative and most positive values. Operands with an odd and an even lowest bit are also used. Together these separate a signed test from an unsigned one, and an equality test from an ordering test. Displacements at the positive limit, the negative limit and zero show whether sign extension and scaling happen in the right order. Jumps with unaligned operands and link fields of 31 isolate the alignment and discard paths. Idle cycles with changing inputs show that results are held.

// File: rtl/ctl_xfer_pkg.sv
package ctl_xfer_pkg;
  // Low three opcode bits of the conditional group select the test.
  typedef enum logic [2:0] {
    CT_LBC = 3'd0, CT_EQ = 3'd1, CT_LT = 3'd2, CT_LE = 3'd3,
    CT_LBS = 3'd4, CT_NE = 3'd5, CT_GE = 3'd6, CT_GT = 3'd7
  } cond_e;

  typedef enum logic [1:0] {
    XK_ILLEGAL, XK_DIRECT, XK_CONDITIONAL, XK_INDIRECT
  } xfer_kind_e;

  localparam logic [5:0] OPC_JUMP     = 6'h1A;
  localparam logic [5:0] OPC_BR       = 6'h30;
  localparam logic [5:0] OPC_BSR      = 6'h34;
  localparam logic [2:0] OPC_CND_HIGH = 3'b111;
endpackage

// File: rtl/ctl_xfer_dec.sv
module ctl_xfer_dec
  import ctl_xfer_pkg::*;
#(
  parameter int OPCW = 6
) (
  input  logic [OPCW-1:0] opc,
  output xfer_kind_e      kind,
  output cond_e           csel
);
  always_comb begin
    csel = cond_e'(opc[2:0]);
    if (opc == OPCW'(OPC_BR) || opc == OPCW'(OPC_BSR))
      kind = XK_DIRECT;
    else if (opc == OPCW'(OPC_JUMP))
      kind = XK_INDIRECT;
    else if (opc[OPCW-1:3] == (OPCW-3)'(OPC_CND_HIGH))
      kind = XK_CONDITIONAL;
    else
      kind = XK_ILLEGAL;
  end
endmodule

// File: rtl/ctl_xfer_cond.sv
module ctl_xfer_cond
  import ctl_xfer_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] opnd,
  input  cond_e           csel,
  output logic            hit
);
  logic is_zero;
  logic is_neg;

  assign is_zero = (opnd == '0);
  assign is_neg  = opnd[XLEN-1];

  always_comb begin
    unique case (csel)
      CT_LBC:  hit = ~opnd[0];
      CT_LBS:  hit = opnd[0];
      CT_EQ:   hit = is_zero;
      CT_NE:   hit = ~is_zero;
      CT_LT:   hit = is_neg;
      CT_LE:   hit = is_neg | is_zero;
      CT_GE:   hit = ~is_neg;
      CT_GT:   hit = ~is_neg & ~is_zero;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/ctl_xfer_tgt.sv
module ctl_xfer_tgt #(
  parameter int XLEN  = 64,
  parameter int DISPW = 21,
  parameter int SHAMT = 2
) (
  input  logic [XLEN-1:0]  seq_pc,
  input  logic [DISPW-1:0] disp,
  input  logic [XLEN-1:0]  jreg,
  output logic [XLEN-1:0]  rel_tgt,
  output logic [XLEN-1:0]  abs_tgt
);
  localparam int EXTW = XLEN - DISPW - SHAMT;
  localparam logic [XLEN-1:0] ALIGN_MASK = ~XLEN'((1 << SHAMT) - 1);

  logic [XLEN-1:0] offset;

  // Sign-extend the word displacement, then scale to bytes.
  assign offset  = {{EXTW{disp[DISPW-1]}}, disp, {SHAMT{1'b0}}};
  assign rel_tgt = seq_pc + offset;
  assign abs_tgt = jreg & ALIGN_MASK;
endmodule

// File: rtl/ctl_xfer_unit.sv
module ctl_xfer_unit
  import ctl_xfer_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int ILEN  = 32,
  parameter int REGW  = 5,
  parameter int DISPW = 21,
  parameter int SHAMT = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_vld,
  input  logic [ILEN-1:0] insn,
  input  logic [XLEN-1:0] seq_pc,
  input  logic [XLEN-1:0] opa_val,
  input  logic [XLEN-1:0] opb_val,
  output logic            res_vld,
  output logic            taken,
  output logic [XLEN-1:0] target,
  output logic            link_we,
  output logic [REGW-1:0] link_idx,
  output logic [XLEN-1:0] link_val,
  output logic            illegal
);
  localparam int OPCW = ILEN - REGW - DISPW;
  localparam logic [REGW-1:0] SINK_REG = '1;

  logic [OPCW-1:0]  opc;
  logic [REGW-1:0]  ra_idx;
  logic [DISPW-1:0] disp;
  xfer_kind_e       kind;
  cond_e            csel;
  logic             cond_hit;
  logic [XLEN-1:0]  rel_tgt;
  logic [XLEN-1:0]  abs_tgt;

  assign opc    = insn[ILEN-1 -: OPCW];
  assign ra_idx = insn[DISPW+REGW-1 -: REGW];
  assign disp   = insn[DISPW-1:0];

  ctl_xfer_dec #(.OPCW(OPCW)) u_dec (
    .opc  (opc),
    .kind (kind),
    .csel (csel)
  );

  ctl_xfer_cond #(.XLEN(XLEN)) u_cond (
    .opnd (opa_val),
    .csel (csel),
    .hit  (cond_hit)
  );

  ctl_xfer_tgt #(.XLEN(XLEN), .DISPW(DISPW), .SHAMT(SHAMT)) u_tgt (
    .seq_pc  (seq_pc),
    .disp    (disp),
    .jreg    (opb_val),
    .rel_tgt (rel_tgt),
    .abs_tgt (abs_tgt)
  );

  // Next-state
  logic            taken_d;
  logic [XLEN-1:0] target_d;
  logic            link_we_d;
  logic [REGW-1:0] link_idx_d;
  logic [XLEN-1:0] link_val_d;
  logic            illegal_d;
  logic            wants_link;

  always_comb begin
    taken_d    = 1'b0;
    target_d   = seq_pc;
    illegal_d  = 1'b0;
    wants_link = 1'b0;
    unique case (kind)
      XK_DIRECT: begin
        taken_d    = 1'b1;
        target_d   = rel_tgt;
        wants_link = 1'b1;
      end
      XK_CONDITIONAL: begin
        taken_d  = cond_hit;
        target_d = cond_hit ? rel_tgt : seq_pc;
      end
      XK_INDIRECT: begin
        taken_d    = 1'b1;
        target_d   = abs_tgt;
        wants_link = 1'b1;
      end
      default: illegal_d = 1'b1;
    endcase
    link_we_d  = wants_link && (ra_idx != SINK_REG);
    link_idx_d = link_we_d ? ra_idx : '0;
    link_val_d = link_we_d ? seq_pc : '0;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld  <= 1'b0;
      taken    <= 1'b0;
      target   <= '0;
      link_we  <= 1'b0;
      link_idx <= '0;
      link_val <= '0;
      illegal  <= 1'b0;
    end else begin
      res_vld <= req_vld;
      if (req_vld) begin
        taken    <= taken_d;
        target   <= target_d;
        link_we  <= link_we_d;
        link_idx <= link_idx_d;
        link_val <= link_val_d;
        illegal  <= illegal_d;
      end
    end
  end
endmodule

// File: rtl/ctl_xfer_chk.sv
module ctl_xfer_chk #(
  parameter int XLEN = 64,
  parameter int REGW = 5,
  parameter int OPCW = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_vld,
  input logic [OPCW-1:0] opc_in,
  input logic [XLEN-1:0] seq_pc,
  input logic            res_vld,
  input logic            taken,
  input logic [XLEN-1:0] target,
  input logic            link_we,
  input logic [REGW-1:0] link_idx,
  input logic            illegal
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> res_vld); // R1
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> !res_vld); // R1
  AST_NO_SINK_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> (link_idx != '1)); // R4
  AST_JUMP_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld && opc_in == OPCW'(6'h1A) |=> taken && (target[1:0] == 2'b00)); // R8
  AST_FALLTHRU_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> (taken || (target == $past(seq_pc)))); // R9
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!taken && !link_we)); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> ($stable(target) && $stable(taken) && $stable(illegal))); // R11
endmodule

bind ctl_xfer_unit ctl_xfer_chk #(.XLEN(XLEN), .REGW(REGW), .OPCW(OPCW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_vld  (req_vld),
  .opc_in   (insn[ILEN-1 -: OPCW]),
  .seq_pc   (seq_pc),
  .res_vld  (res_vld),
  .taken    (taken),
  .target   (target),
  .link_we  (link_we),
  .link_idx (link_idx),
  .illegal  (illegal)
);

// File: tb/ctl_xfer_unit_tb_top.sv
`timescale 1ns/1ps
module ctl_xfer_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_vld;
  logic [31:0] insn;
  logic [63:0] seq_pc, opa_val, opb_val;
  logic        res_vld, taken, link_we, illegal;
  logic [63:0] target, link_val;
  logic [4:0]  link_idx;

  always #2 clk = ~clk;

  ctl_xfer_unit dut_i (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .insn(insn),
    .seq_pc(seq_pc), .opa_val(opa_val), .opb_val(opb_val),
    .res_vld(res_vld), .taken(taken), .target(target),
    .link_we(link_we), .link_idx(link_idx), .link_val(link_val),
    .illegal(illegal)
  );

  int n_chk = 0;
  int n_fail = 0;

  // Behavioural expectation of the registered outputs
  logic        e_vld = 0, e_tk = 0, e_lwe = 0, e_ill = 0;
  logic [63:0] e_tgt = 0, e_lval = 0;
  logic [4:0]  e_lidx = 0;

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] ra,
                                     input logic [20:0] low);
    return {op, ra, low};
  endfunction

  task automatic model(input logic [31:0] w, input logic [63:0] sp,
                       input logic [63:0] a, input logic [63:0] b);
    int op;
    longint sa;
    longint off;
    logic signed [20:0] d;
    bit cond, islink;
    op  = int'(w[31:26]);
    sa  = longint'(a);
    d   = w[20:0];
    off = longint'(d) * 4;
    e_ill = 0; e_tk = 0; e_tgt = sp; islink = 0;
    if (op == 'h30 || op == 'h34) begin
      e_tk = 1; e_tgt = sp + 64'(off); islink = 1;
    end else if (op == 'h1A) begin
      e_tk = 1; e_tgt = {b[63:2], 2'b00}; islink = 1;
    end else if (op >= 'h38 && op <= 'h3F) begin
      case (op)
        'h38: cond = (a[0] == 1'b0);
        'h3C: cond = (a[0] == 1'b1);
        'h39: cond = (sa == 0);
        'h3D: cond = (sa != 0);
        'h3A: cond = (sa < 0);
        'h3B: cond = (sa <= 0);
        'h3E: cond = (sa >= 0);
        default: cond = (sa > 0);
      endcase
      e_tk = cond;
      if (cond) e_tgt = sp + 64'(off);
    end else begin
      e_ill = 1;
    end
    e_lwe  = islink && (w[25:21] != 5'd31);
    e_lidx = e_lwe ? w[25:21] : 5'd0;
    e_lval = e_lwe ? sp : 64'd0;
  endtask

  task automatic compare(input string tag);
    n_chk++;
    if (res_vld !== e_vld || taken !== e_tk || target !== e_tgt ||
        link_we !== e_lwe || link_idx !== e_lidx || link_val !== e_lval ||
        illegal !== e_ill) begin
      n_fail++;
      $display("FAIL %s actual vld=%0b tk=%0b tgt=%h lwe=%0b lidx=%0d lval=%h ill=%0b expected vld=%0b tk=%0b tgt=%h lwe=%0b lidx=%0d lval=%h ill=%0b",
               tag, res_vld, taken, target, link_we, link_idx, link_val, illegal,
               e_vld, e_tk, e_tgt, e_lwe, e_lidx, e_lval, e_ill);
    end
  endtask

  // Called at a falling edge: drive, let one rising edge pass, compare.
  task automatic step(input bit v, input logic [31:0] w, input logic [63:0] sp,
                      input logic [63:0] a, input logic [63:0] b, input string tag);
    req_vld = v; insn = w; seq_pc = sp; opa_val = a; opb_val = b;
    if (v) model(w, sp, a, b);
    e_vld = v;
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  localparam logic [63:0] PC0  = 64'h0000_0001_2000_1004;
  localparam logic [63:0] SMIN = 64'h8000_0000_0000_0000;
  localparam logic [63:0] SMAX = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] M1   = 64'hFFFF_FFFF_FFFF_FFFF;

  initial begin
    #(4 * 100000);
    n_fail++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [5:0] ops[14];
    ops = '{6'h30, 6'h34, 6'h1A, 6'h38, 6'h39, 6'h3A, 6'h3B,
            6'h3C, 6'h3D, 6'h3E, 6'h3F, 6'h00, 6'h31, 6'h2F};
    rst_n = 0; req_vld = 0; insn = '0; seq_pc = '0; opa_val = '0; opb_val = '0;
    repeat (3) @(negedge clk);
    compare("R2 reset");
    rst_n = 1;
    step(0, '0, '0, '0, '0, "R1 idle after reset");

    // R3 direct branches and displacement limits
    step(1, mk(6'h30, 5'd4, 21'h000010), PC0, 0, 0, "R3 br fwd");
    step(1, mk(6'h30, 5'd4, 21'h0FFFFF), PC0, 0, 0, "R3 br max fwd");
    step(1, mk(6'h34, 5'd26, 21'h100000), PC0, 0, 0, "R3 bsr max back");
    step(1, mk(6'h34, 5'd26, 21'h1FFFFF), PC0, 0, 0, "R3 bsr minus one word");
    step(1, mk(6'h30, 5'd0, 21'h000000), PC0, 0, 0, "R3 br zero disp");
    // R4 link discard on register 31
    step(1, mk(6'h30, 5'd31, 21'h000020), PC0, 0, 0, "R4 br sink");
    step(1, mk(6'h1A, 5'd31, {5'd3, 16'h0}), PC0, 0, 64'h1234_5677, "R4 jump sink");
    // R8 jumps with unaligned operands
    step(1, mk(6'h1A, 5'd26, {5'd3, 16'h4000}), PC0, 0, 64'hDEAD_BEEF_0000_0013, "R8 jump low bits");
    step(1, mk(6'h1A, 5'd1, 21'h0), PC0, 0, M1, "R8 jump all ones");
    // R5 low bit tests
    step(1, mk(6'h38, 5'd2, 21'h8), PC0, 64'h2, 0, "R5 lbc even");
    step(1, mk(6'h38, 5'd2, 21'h8), PC0, 64'h3, 0, "R5 lbc odd");
    step(1, mk(6'h3C, 5'd2, 21'h8), PC0, M1, 0, "R5 lbs odd");
    step(1, mk(6'h3C, 5'd2, 21'h8), PC0, SMIN, 0, "R5 lbs even");
    // R6 zero tests
    step(1, mk(6'h39, 5'd5, 21'h1F0000), PC0, 0, 0, "R6 eq zero");
    step(1, mk(6'h39, 5'd5, 21'h1F0000), PC0, SMIN, 0, "R6 eq nonzero");
    step(1, mk(6'h3D, 5'd5, 21'h40), PC0, 64'h1, 0, "R6 ne one");
    step(1, mk(6'h3D, 5'd5, 21'h40), PC0, 0, 0, "R6 ne zero");
    // R7 signed tests at edges
    begin
      logic [63:0] vals[5];
      vals = '{64'd0, M1, 64'd1, SMIN, SMAX};
      foreach (vals[i]) begin
        step(1, mk(6'h3A, 5'd7, 21'h30), PC0, vals[i], 0, "R7 lt");
        step(1, mk(6'h3B, 5'd7, 21'h30), PC0, vals[i], 0, "R7 le");
        step(1, mk(6'h3E, 5'd7, 21'h1FFFF0), PC0, vals[i], 0, "R7 ge");
        step(1, mk(6'h3F, 5'd7, 21'h1FFFF0), PC0, vals[i], 0, "R7 gt");
      end
    end
    // R9 not taken keeps sequential address, no link
    step(1, mk(6'h3F, 5'd9, 21'h100), 64'h40, 64'd0, 0, "R9 fallthrough");
    // R10 illegal opcodes
    step(1, mk(6'h00, 5'd3, 21'h0), PC0, 0, 0, "R10 op00");
    step(1, mk(6'h10, 5'd3, 21'h5), PC0, 0, 0, "R10 op10");
    step(1, mk(6'h31, 5'd3, 21'h5), PC0, 0, 0, "R10 op31");
    step(1, mk(6'h1B, 5'd3, 21'h5), PC0, 0, 0, "R10 op1B");
    // R11 hold with changing inputs
    step(1, mk(6'h34, 5'd26, 21'h77), PC0, 0, 0, "R11 load");
    step(0, mk(6'h1A, 5'd1, 21'h0), 64'h999, M1, M1, "R11 hold a");
    step(0, mk(6'h00, 5'd1, 21'h0), 64'h123, 0, 0, "R11 hold b");
    // Mixed sequence, every clock compared
    for (int k = 0; k < 400; k++) begin
      logic [5:0] op;
      logic [63:0] a;
      op = ops[$urandom_range(13)];
      case ($urandom_range(3))
        0: a = 64'd0;
        1: a = M1;
        default: a = {$urandom, $urandom};
      endcase
      step($urandom_range(4) != 0, mk(op, 5'($urandom), 21'($urandom)),
           {$urandom, $urandom & 32'hFFFF_FFFC}, a, {$urandom, $urandom}, "R3 R7 mixed");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule